// File: doc/BRIEF.md
# ADC Conversion Clock Divider and Startup Timer

This block turns a fast peripheral clock into the slower conversion clock of a successive-approximation ADC sequencer. It does not produce a second clock. It produces a one-cycle clock-enable pulse on each rising phase of a virtual ADC clock. The ADC clock period is set by an 8-bit divide value through a divide-by-2×(N+1) counter.

The block also times the analog settling delay that must pass before the first conversion after a reset, a synchronous restart or a wake request. A 4-bit settling code selects one of sixteen fixed, non-linear counts of ADC-clock periods. The ready flag rises once that many enable pulses have been seen. The sequencer holds its conversions until ready is high.

Top module: `adc_clk_prescaler`

## Requirements
- R1: `adc_ce_o` is high for exactly one cycle at a time. With a steady divide value P, consecutive pulses are 2×(P+1) peripheral cycles apart.
- R2: While `rst_n` is low, `adc_ce_o` and `ready_o` are 0. The first pulse on `adc_ce_o` is visible after the first rising edge following reset release.
- R3: `presc_i` is sampled only when the divider reloads, which happens at each half-period boundary. After a change from Pa to Pb right after a pulse, the next gap is (Pa+1)+(Pb+1) cycles, and every later gap is 2×(Pb+1).
- R4: The settling code c maps to a count T as follows: c=0..3 gives 8·c; c=4..7 gives 64+16·(c−4); c=8..15 gives 512+64·(c−8). Start at the edge that ends reset (or a restart). Let D = 2×(P+1). Then `ready_o` first reads 1 after edge 1 when T=0, and after edge 2+(T−1)·D otherwise.
- R5: Once `ready_o` is 1, it stays 1 until a wake or a restart request, whatever happens on `presc_i` or `su_code_i`.
- R6: A one-cycle `wake_i` reloads the settling count from the current code. `ready_o` is then 0 for any nonzero code. It becomes 1 one cycle after the T-th enable pulse that follows the wake edge. The enable cadence is not disturbed.
- R7: A one-cycle `soft_rst_i` returns the divider and the settling timer to their reset state. `adc_ce_o` and `ready_o` are 0 in the next cycle, and the timing of R2 and R4 then repeats.
- R8: A change of `su_code_i` while a settling count is in progress has no effect on when `ready_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous restart of divider and settling timer |
| wake_i | input | 1 | Restart the settling count only |
| presc_i | input | PRESC_W | Divide value P |
| su_code_i | input | 4 | Settling code |
| adc_ce_o | output | 1 | One-cycle ADC clock enable on each rising phase |
| adc_phase_o | output | 1 | Current ADC clock phase |
| ready_o | output | 1 | Settling delay elapsed |

## Verification
The hardest case to reach is a divide-value change that lands partway through an ADC clock period. The new value must take effect at the half-period reload, not at once and not a full period late. The stimulus changes `presc_i` in the cycle just after a pulse, then measures the next two gaps. The largest settling codes are reached within the cycle budget by running them at the smallest divide values. Wake requests are placed at arbitrary divider phases, so the count of pulses after the wake, rather than a fixed cycle number, decides the check.

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler #(
  parameter int PRESC_W = 8,
  parameter int SU_W    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst_i,
  input  logic               wake_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [3:0]         su_code_i,
  output logic               adc_ce_o,
  output logic               adc_phase_o,
  output logic               ready_o
);

  logic [PRESC_W-1:0] div_q;
  logic               phase_q;
  logic               ce_q;
  logic               load_q;
  logic [SU_W-1:0]    su_q;

  wire term = (div_q == '0);

  function automatic logic [SU_W-1:0] su_lookup(input logic [3:0] c);
    if (c[3])      return SU_W'(512 + 64 * int'(c[2:0]));
    else if (c[2]) return SU_W'(64 + 16 * int'(c[1:0]));
    else           return SU_W'(8 * int'(c[1:0]));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
      ce_q    <= 1'b0;
      load_q  <= 1'b1;
      su_q    <= '0;
    end else if (soft_rst_i) begin
      div_q   <= '0;
      phase_q <= 1'b0;
      ce_q    <= 1'b0;
      load_q  <= 1'b1;
      su_q    <= '0;
    end else begin
      if (term) begin
        div_q   <= presc_i;
        phase_q <= ~phase_q;
      end else begin
        div_q <= div_q - 1'b1;
      end
      ce_q   <= term & ~phase_q;
      load_q <= 1'b0;
      if (load_q || wake_i)
        su_q <= su_lookup(su_code_i);
      else if (ce_q && su_q != '0)
        su_q <= su_q - 1'b1;
    end
  end

  assign adc_ce_o    = ce_q;
  assign adc_phase_o = phase_q;
  assign ready_o     = ~load_q & (su_q == '0);

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ce_o |=> !adc_ce_o);

  assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !wake_i && !soft_rst_i) |=> ready_o);

  assert_wake_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_i && !soft_rst_i && su_code_i != 4'd0) |=> !ready_o);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!adc_ce_o && !ready_o));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ce_o && su_q != '0 && !wake_i && !soft_rst_i && !load_q)
      |=> su_q == $past(su_q) - 1'b1);

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_ce_o && !wake_i && !soft_rst_i && !load_q) |=> $stable(su_q));

endmodule

// File: tb/adc_clk_prescaler_tb_top.sv
module adc_clk_prescaler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       wake_i = 1'b0;
  logic [7:0] presc_i = 8'd0;
  logic [3:0] su_code_i = 4'd0;
  logic       adc_ce_o, adc_phase_o, ready_o;

  int n_checks = 0;
  int n_fails = 0;
  int cyc = 0;

  adc_clk_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .wake_i(wake_i),
    .presc_i(presc_i), .su_code_i(su_code_i),
    .adc_ce_o(adc_ce_o), .adc_phase_o(adc_phase_o), .ready_o(ready_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: actual %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  function automatic int exp_t(input int c);
    int tbl [16] = '{0, 8, 16, 24, 64, 80, 96, 112,
                     512, 576, 640, 704, 768, 832, 896, 960};
    return tbl[c];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ce();
    for (int i = 0; i < 2000 && !adc_ce_o; i++) tick();
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin
      tick();
      g++;
    end while (!adc_ce_o && g < 2000);
  endtask

  task automatic restart();
    soft_rst_i = 1'b1;
    tick();
    soft_rst_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(adc_ce_o == 0, "R2 ce in reset", adc_ce_o, 0);
    chk(ready_o == 0, "R2 ready in reset", ready_o, 0);
    rst_n = 1'b1;
    tick();
    chk(adc_ce_o == 1, "R2 first pulse", adc_ce_o, 1);
    tick();
    chk(adc_ce_o == 0, "R1 pulse width", adc_ce_o, 0);
  endtask

  task automatic t_period(input int p);
    int g;
    presc_i = 8'(p);
    wait_ce();
    gap(g);
    gap(g);
    chk(g == 2 * (p + 1), "R1 period", g, 2 * (p + 1));
    gap(g);
    chk(g == 2 * (p + 1), "R1 period repeat", g, 2 * (p + 1));
  endtask

  task automatic t_presc_change();
    int g;
    presc_i = 8'd2;
    wait_ce(); gap(g); gap(g);
    presc_i = 8'd5;
    gap(g);
    chk(g == 9, "R3 transition gap", g, 9);
    gap(g);
    chk(g == 12, "R3 new period", g, 12);
  endtask

  task automatic t_startup(input int c, input int p);
    int n, e, d;
    presc_i = 8'(p);
    su_code_i = 4'(c);
    restart();
    chk(ready_o == 0 && adc_ce_o == 0, "R7 restart clears", {ready_o, adc_ce_o}, 0);
    d = 2 * (p + 1);
    e = (exp_t(c) == 0) ? 1 : 2 + (exp_t(c) - 1) * d;
    n = 0;
    do begin
      tick();
      n++;
    end while (!ready_o && n < 5000);
    chk(n == e, $sformatf("R4 code %0d", c), n, e);
  endtask

  task automatic t_ready_hold();
    bit ok = 1;
    t_startup(2, 0);
    for (int i = 0; i < 40; i++) begin
      su_code_i = 4'(i);
      presc_i = 8'(i % 3);
      tick();
      if (!ready_o) ok = 0;
    end
    chk(ok, "R5 ready held", ok, 1);
  endtask

  task automatic t_wake(input int c);
    int n, g;
    presc_i = 8'd1;
    su_code_i = 4'(c);
    wait_ce();
    tick();
    wake_i = 1'b1;
    tick();
    wake_i = 1'b0;
    chk(ready_o == 0, "R6 wake drops ready", ready_o, 0);
    n = 0;
    g = 0;
    for (int i = 0; i < 5000 && !ready_o; i++) begin
      if (adc_ce_o) n++;
      tick();
    end
    chk(n == exp_t(c), "R6 pulses to ready", n, exp_t(c));
    wait_ce();
    gap(g);
    chk(g == 4, "R6 cadence kept", g, 4);
  endtask

  task automatic t_code_change();
    int n;
    presc_i = 8'd0;
    su_code_i = 4'd5;
    restart();
    for (int i = 0; i < 10; i++) tick();
    su_code_i = 4'd15;
    n = 10;
    do begin
      tick();
      n++;
    end while (!ready_o && n < 5000);
    chk(n == 160, "R8 code change ignored", n, 160);
  endtask

  initial begin
    t_reset();
    t_period(0);
    t_period(3);
    t_period(255);
    t_presc_change();
    for (int c = 0; c < 16; c++) t_startup(c, 1);
    t_startup(3, 6);
    t_ready_hold();
    t_wake(2);
    t_wake(5);
    t_code_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule